// File: doc/BRIEF.md
# Double-Buffered Multi-Word Control Register

This block holds one control/status value that is wider than the processor data word. The value is spread over `NUM_WORDS` consecutive word addresses starting at `BASE_ADDR`. Software writes do not reach the live value one word at a time. Each written word goes into a staging buffer. The staged value then moves into the live register in a single cycle when a commit trigger fires. Software reads work the same way in reverse. A snapshot of the whole live value is captured on a read trigger, and every word that software reads comes from that snapshot. A multi-word value is therefore never seen half old and half new.

Hardware sees the live value all the time and can load it through an update port. A software commit takes precedence over a hardware update in the same cycle. Two strobes mark the software access events. One is high in the cycle the live value is being replaced by a commit. The other is high in the cycle the live value is being sampled into the snapshot. Parameters select the trigger sources. The commit comes either from a write to the highest word or from an external pulse. The snapshot comes either from a read of the lowest word or from an external pulse.

Top module: `wide_csr_dbuf`

## Requirements
- R1: While reset is low and in the first cycle after it, `hw_value` equals `RESET_VAL`, `rsp_ack` is 0, both strobes are 0, and the staging buffer and the snapshot also hold `RESET_VAL`.
- R2: A write to word k (address `BASE_ADDR`+k, k from 0 to `NUM_WORDS`-1) stores `req_wdata` into bits [k*WORD_W +: WORD_W] of the staging buffer only. `hw_value` does not change unless a commit fires.
- R3: With `WTRIG_SEL` = last-word, a write to address `BASE_ADDR`+`NUM_WORDS`-1 is the commit. `hw_value` takes the staged value, including that word, at the clock edge that ends the write cycle.
- R4: With `WTRIG_SEL` = external, the commit happens in any cycle in which `ext_wtrig` is 1. A word written in that same cycle is included in the commit. A write to the highest word does not commit on its own.
- R5: Staged words that were not written since the last commit keep their earlier staged value and are committed again unchanged.
- R6: When `hw_upd_en` is 1 and no commit fires, `hw_value` takes `hw_upd_data` at the next edge. When both occur in the same cycle, the commit wins.
- R7: With `RTRIG_SEL` = first-word, a read of `BASE_ADDR` captures the whole live value into the snapshot. That read returns live word 0.
- R8: A read of any word that has no snapshot trigger in the same cycle returns the word from the last snapshot. It does not return the live value.
- R9: With `RTRIG_SEL` = external, the snapshot is captured in any cycle in which `ext_rtrig` is 1. A read in that same cycle returns the live word. Reads of `BASE_ADDR` do not capture on their own.
- R10: One cycle after an in-range request, `rsp_ack` is 1 for one cycle. `rsp_rdata` carries the word for a read and 0 otherwise. A request outside the address window gets no acknowledge and changes no state.
- R11: `sw_wr_strobe` is 1 exactly in the cycles in which a commit fires.
- R12: `sw_rd_strobe` is 1 exactly in the cycles in which the snapshot is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write word |
| rsp_ack | output | 1 | Request acknowledged, one cycle after it |
| rsp_rdata | output | WORD_W | Read word, valid with `rsp_ack` |
| hw_value | output | WORD_W*NUM_WORDS | Live register value |
| hw_upd_en | input | 1 | Hardware load enable |
| hw_upd_data | input | WORD_W*NUM_WORDS | Hardware load value |
| ext_wtrig | input | 1 | External commit pulse (external commit mode) |
| ext_rtrig | input | 1 | External snapshot pulse (external snapshot mode) |
| sw_rd_strobe | output | 1 | Live value sampled into the snapshot this cycle |
| sw_wr_strobe | output | 1 | Live value replaced by a commit this cycle |

## Verification
A bad live value shows on `hw_value` one cycle after the cycle that caused it. A bad staged word stays hidden until the next commit and then shows on `hw_value`. A bad snapshot word shows on `rsp_rdata` one cycle after the read that returns it. This can happen many cycles after the snapshot was taken. For that reason the stimulus changes the live value between a snapshot and the reads that follow it. It also leaves staged words unwritten across commits. Two instances are compared side by side, one with the word-address triggers and one with the external triggers. This shows trigger selection and same-cycle priority directly at the strobes and at `hw_value`.

// File: rtl/csr_dbuf_pkg.sv
package csr_dbuf_pkg;
    typedef enum logic {
        WTRIG_LAST_WORD = 1'b0,
        WTRIG_EXTERNAL  = 1'b1
    } wtrig_sel_e;

    typedef enum logic {
        RTRIG_FIRST_WORD = 1'b0,
        RTRIG_EXTERNAL   = 1'b1
    } rtrig_sel_e;
endpackage

// File: rtl/csr_word_decode.sv
module csr_word_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4,
    parameter int BASE_ADDR = 16,
    parameter int IDX_W     = 2
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              is_first,
    output logic              is_last
);
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(NUM_WORDS - 1);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off      = req_addr - BASE;
        hit      = req_valid && (req_addr >= BASE) && (off <= LAST_OFF);
        idx      = off[IDX_W-1:0];
        is_first = hit && (off == '0);
        is_last  = hit && (off == LAST_OFF);
    end
endmodule

// File: rtl/csr_wr_stage.sv
module csr_wr_stage
    import csr_dbuf_pkg::*;
#(
    parameter int                 WORD_W    = 32,
    parameter int                 IDX_W     = 2,
    parameter int                 TOTAL_W   = 128,
    parameter logic [TOTAL_W-1:0] RESET_VAL = '0,
    parameter wtrig_sel_e         WTRIG_SEL = WTRIG_LAST_WORD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [IDX_W-1:0]   idx,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               wr_last,
    input  logic               ext_trig,
    output logic               commit,
    output logic [TOTAL_W-1:0] commit_val
);
    typedef struct packed {
        logic [TOTAL_W-1:0] wbuf;
    } wst_t;

    wst_t st_d, st_q;
    logic [TOTAL_W-1:0] merged;

    always_comb begin
        merged = st_q.wbuf;
        if (wr_hit) begin
            merged[idx*WORD_W +: WORD_W] = wdata;
        end
        st_d.wbuf  = merged;
        commit     = (WTRIG_SEL == WTRIG_LAST_WORD) ? (wr_hit && wr_last) : ext_trig;
        commit_val = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wbuf <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/csr_rd_snap.sv
module csr_rd_snap
    import csr_dbuf_pkg::*;
#(
    parameter int                 WORD_W    = 32,
    parameter int                 IDX_W     = 2,
    parameter int                 TOTAL_W   = 128,
    parameter logic [TOTAL_W-1:0] RESET_VAL = '0,
    parameter rtrig_sel_e         RTRIG_SEL = RTRIG_FIRST_WORD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_hit,
    input  logic [IDX_W-1:0]   idx,
    input  logic               rd_first,
    input  logic               ext_trig,
    input  logic [TOTAL_W-1:0] live,
    output logic               snap_fire,
    output logic [WORD_W-1:0]  rd_word
);
    typedef struct packed {
        logic [TOTAL_W-1:0] rbuf;
    } rst_t;

    rst_t st_d, st_q;
    logic [TOTAL_W-1:0] src;

    always_comb begin
        snap_fire = (RTRIG_SEL == RTRIG_FIRST_WORD) ? (rd_hit && rd_first) : ext_trig;
        src       = snap_fire ? live : st_q.rbuf;
        rd_word   = src[idx*WORD_W +: WORD_W];
        st_d.rbuf = src;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rbuf <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wide_csr_dbuf.sv
module wide_csr_dbuf
    import csr_dbuf_pkg::*;
#(
    parameter int                              WORD_W    = 32,
    parameter int                              NUM_WORDS = 4,
    parameter int                              ADDR_W    = 8,
    parameter int                              BASE_ADDR = 16,
    parameter logic [WORD_W*NUM_WORDS-1:0]     RESET_VAL = '0,
    parameter wtrig_sel_e                      WTRIG_SEL = WTRIG_LAST_WORD,
    parameter rtrig_sel_e                      RTRIG_SEL = RTRIG_FIRST_WORD
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [WORD_W-1:0]             req_wdata,
    output logic                          rsp_ack,
    output logic [WORD_W-1:0]             rsp_rdata,
    output logic [WORD_W*NUM_WORDS-1:0]   hw_value,
    input  logic                          hw_upd_en,
    input  logic [WORD_W*NUM_WORDS-1:0]   hw_upd_data,
    input  logic                          ext_wtrig,
    input  logic                          ext_rtrig,
    output logic                          sw_rd_strobe,
    output logic                          sw_wr_strobe
);
    localparam int TOTAL_W = WORD_W * NUM_WORDS;
    localparam int IDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    typedef struct packed {
        logic [TOTAL_W-1:0] live;
        logic               ack;
        logic [WORD_W-1:0]  rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic               hit, is_first, is_last;
    logic [IDX_W-1:0]   idx;
    logic               wr_hit, rd_hit;
    logic               commit, snap_fire;
    logic [TOTAL_W-1:0] commit_val;
    logic [WORD_W-1:0]  rd_word;

    csr_word_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
    ) u_dec (
        .req_valid(req_valid), .req_addr(req_addr), .hit(hit),
        .idx(idx), .is_first(is_first), .is_last(is_last)
    );

    assign wr_hit = hit && req_write;
    assign rd_hit = hit && !req_write;

    csr_wr_stage #(
        .WORD_W(WORD_W), .IDX_W(IDX_W), .TOTAL_W(TOTAL_W),
        .RESET_VAL(RESET_VAL), .WTRIG_SEL(WTRIG_SEL)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .idx(idx), .wdata(req_wdata),
        .wr_last(is_last), .ext_trig(ext_wtrig), .commit(commit), .commit_val(commit_val)
    );

    csr_rd_snap #(
        .WORD_W(WORD_W), .IDX_W(IDX_W), .TOTAL_W(TOTAL_W),
        .RESET_VAL(RESET_VAL), .RTRIG_SEL(RTRIG_SEL)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .idx(idx), .rd_first(is_first),
        .ext_trig(ext_rtrig), .live(st_q.live), .snap_fire(snap_fire), .rd_word(rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.live = commit_val;
        end else if (hw_upd_en) begin
            st_d.live = hw_upd_data;
        end
        st_d.ack   = hit;
        st_d.rdata = rd_hit ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.live  <= RESET_VAL;
            st_q.ack   <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hw_value     = st_q.live;
    assign rsp_ack      = st_q.ack;
    assign rsp_rdata    = st_q.rdata;
    assign sw_wr_strobe = commit;
    assign sw_rd_strobe = snap_fire;
endmodule

// File: rtl/csr_dbuf_checker.sv
module csr_dbuf_checker
    import csr_dbuf_pkg::*;
#(
    parameter int                          WORD_W    = 32,
    parameter int                          NUM_WORDS = 4,
    parameter int                          ADDR_W    = 8,
    parameter int                          BASE_ADDR = 16,
    parameter logic [WORD_W*NUM_WORDS-1:0] RESET_VAL = '0,
    parameter wtrig_sel_e                  WTRIG_SEL = WTRIG_LAST_WORD,
    parameter rtrig_sel_e                  RTRIG_SEL = RTRIG_FIRST_WORD
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [WORD_W-1:0]           req_wdata,
    input logic                        rsp_ack,
    input logic [WORD_W-1:0]           rsp_rdata,
    input logic [WORD_W*NUM_WORDS-1:0] hw_value,
    input logic                        hw_upd_en,
    input logic [WORD_W*NUM_WORDS-1:0] hw_upd_data,
    input logic                        ext_wtrig,
    input logic                        ext_rtrig,
    input logic                        sw_rd_strobe,
    input logic                        sw_wr_strobe
);
    localparam int                TOTAL_W = WORD_W * NUM_WORDS;
    localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(BASE_ADDR + NUM_WORDS - 1);

    logic in_win;
    assign in_win = req_valid && (req_addr >= A_LO) && (req_addr <= A_HI);

    p_reset_value_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (hw_value == RESET_VAL) && !rsp_ack);

    p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_strobe && !hw_upd_en) |=> $stable(hw_value));

    p_last_word_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((WTRIG_SEL == WTRIG_LAST_WORD) && req_valid && req_write && (req_addr == A_HI))
        |=> (hw_value[TOTAL_W-1 -: WORD_W] == $past(req_wdata)));

    p_ext_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (WTRIG_SEL == WTRIG_EXTERNAL) |-> (sw_wr_strobe == ext_wtrig));

    p_hw_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_upd_en && !sw_wr_strobe) |=> (hw_value == $past(hw_upd_data)));

    p_first_read_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((RTRIG_SEL == RTRIG_FIRST_WORD) && req_valid && !req_write && (req_addr == A_LO))
        |=> (rsp_rdata == $past(hw_value[WORD_W-1:0])));

    p_ext_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (RTRIG_SEL == RTRIG_EXTERNAL) |-> (sw_rd_strobe == ext_rtrig));

    p_ack_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |=> rsp_ack);

    p_no_ack_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |=> (!rsp_ack && (rsp_rdata == '0)));

    p_wr_strobe_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_strobe && (WTRIG_SEL == WTRIG_LAST_WORD))
        |-> (req_valid && req_write && (req_addr == A_HI)));

    p_rd_strobe_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rd_strobe && (RTRIG_SEL == RTRIG_FIRST_WORD))
        |-> (req_valid && !req_write && (req_addr == A_LO)));
endmodule

bind wide_csr_dbuf csr_dbuf_checker #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .RESET_VAL(RESET_VAL), .WTRIG_SEL(WTRIG_SEL), .RTRIG_SEL(RTRIG_SEL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .hw_value(hw_value), .hw_upd_en(hw_upd_en), .hw_upd_data(hw_upd_data),
    .ext_wtrig(ext_wtrig), .ext_rtrig(ext_rtrig),
    .sw_rd_strobe(sw_rd_strobe), .sw_wr_strobe(sw_wr_strobe)
);

// File: tb/test_wide_csr_dbuf.sv
module test_wide_csr_dbuf;
    import csr_dbuf_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          W    = 16;
    localparam int          N    = 3;
    localparam int          AW   = 4;
    localparam int          BASE = 4;
    localparam logic [47:0] RV   = 48'hA5A5_1234_5678;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0]  req_wdata = '0;
    logic hw_upd_en = 1'b0;
    logic [47:0] hw_upd_data = '0;
    logic ext_wtrig = 1'b0, ext_rtrig = 1'b0;

    logic        o_ack [2];
    logic [W-1:0] o_rd [2];
    logic [47:0] o_val [2];
    logic        o_rs [2];
    logic        o_ws [2];

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_csr_dbuf #(.WORD_W(W), .NUM_WORDS(N), .ADDR_W(AW), .BASE_ADDR(BASE), .RESET_VAL(RV),
        .WTRIG_SEL(WTRIG_LAST_WORD), .RTRIG_SEL(RTRIG_FIRST_WORD)) i_wide_csr_dbuf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(o_ack[0]), .rsp_rdata(o_rd[0]),
        .hw_value(o_val[0]), .hw_upd_en(hw_upd_en), .hw_upd_data(hw_upd_data),
        .ext_wtrig(ext_wtrig), .ext_rtrig(ext_rtrig),
        .sw_rd_strobe(o_rs[0]), .sw_wr_strobe(o_ws[0]));

    wide_csr_dbuf #(.WORD_W(W), .NUM_WORDS(N), .ADDR_W(AW), .BASE_ADDR(BASE), .RESET_VAL(RV),
        .WTRIG_SEL(WTRIG_EXTERNAL), .RTRIG_SEL(RTRIG_EXTERNAL)) i_wide_csr_dbuf_ext (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ack(o_ack[1]), .rsp_rdata(o_rd[1]),
        .hw_value(o_val[1]), .hw_upd_en(hw_upd_en), .hw_upd_data(hw_upd_data),
        .ext_wtrig(ext_wtrig), .ext_rtrig(ext_rtrig),
        .sw_rd_strobe(o_rs[1]), .sw_wr_strobe(o_ws[1]));

    // Reference model: words held in plain arrays, index 0 = word-address trigger variant
    logic [W-1:0] m_live [2][N];
    logic [W-1:0] m_wb   [2][N];
    logic [W-1:0] m_rb   [2][N];
    logic         m_ack  [2];
    logic [W-1:0] m_rd   [2];

    task automatic cmp(input string tag, input int u, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s dut%0d %s: actual %h expected %h", tag, u, what, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic w, input logic [AW-1:0] a, input logic [W-1:0] d,
                       input logic he, input logic [47:0] hd, input logic et, input logic rt,
                       input string tag);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        hw_upd_en = he; hw_upd_data = hd; ext_wtrig = et; ext_rtrig = rt;
        #1;
        begin
            bit hit;
            int k;
            hit = v && (int'(a) >= BASE) && (int'(a) < BASE + N);
            k   = int'(a) - BASE;
            for (int u = 0; u < 2; u++) begin
                bit wc, rf;
                logic [W-1:0] old [N];
                wc = (u == 0) ? (hit && w && k == N-1) : et;
                rf = (u == 0) ? (hit && !w && k == 0) : rt;
                cmp(tag, u, "hw_value", o_val[u], {m_live[u][2], m_live[u][1], m_live[u][0]});
                cmp(tag, u, "rsp_ack", 48'(o_ack[u]), 48'(m_ack[u]));
                cmp(tag, u, "rsp_rdata", 48'(o_rd[u]), 48'(m_rd[u]));
                cmp(tag, u, "sw_wr_strobe", 48'(o_ws[u]), 48'(wc));
                cmp(tag, u, "sw_rd_strobe", 48'(o_rs[u]), 48'(rf));
                if (rst_n) begin
                    for (int j = 0; j < N; j++) old[j] = m_live[u][j];
                    if (hit && w) m_wb[u][k] = d;
                    if (wc) begin
                        for (int j = 0; j < N; j++) m_live[u][j] = m_wb[u][j];
                    end else if (he) begin
                        for (int j = 0; j < N; j++) m_live[u][j] = hd[j*W +: W];
                    end
                    if (rf) begin
                        for (int j = 0; j < N; j++) m_rb[u][j] = old[j];
                    end
                    m_ack[u] = hit;
                    m_rd[u]  = (hit && !w) ? m_rb[u][k] : '0;
                end
            end
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 48'h0, 0, 0, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
        cyc(1, 1, a, d, 0, 48'h0, 0, 0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        cyc(1, 0, a, 0, 0, 48'h0, 0, 0, tag);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic [15:0] lf;
        for (int u = 0; u < 2; u++) begin
            for (int j = 0; j < N; j++) begin
                m_live[u][j] = RV[j*W +: W];
                m_wb[u][j]   = RV[j*W +: W];
                m_rb[u][j]   = RV[j*W +: W];
            end
            m_ack[u] = 1'b0;
            m_rd[u]  = '0;
        end
        // R1: reset values while reset is held and just after
        repeat (3) idle("R1");
        @(negedge clk); rst_n = 1'b1;
        idle("R1");
        rd(5, "R1");              // R1: snapshot still reset value (dut0 no trigger)
        idle("R1");
        // R2: staged writes leave live value alone
        wr(4, 16'h1111, "R2");
        wr(5, 16'h2222, "R2");
        idle("R2");
        // R3 / R11: last word commits
        wr(6, 16'h3333, "R3");
        idle("R11");
        // R5: word 1 not rewritten, kept from staging
        wr(4, 16'h4444, "R5");
        wr(6, 16'h5555, "R5");
        idle("R5");
        // R4: external commit, with and without a same-cycle write
        cyc(0, 0, 0, 0, 0, 48'h0, 1, 0, "R4");
        cyc(1, 1, 5, 16'h6666, 0, 48'h0, 1, 0, "R4");
        idle("R4");
        // R6: hardware load alone, then colliding with a commit
        cyc(0, 0, 0, 0, 1, 48'hBEEF_CAFE_F00D, 0, 0, "R6");
        cyc(1, 1, 6, 16'h7777, 1, 48'h0101_0202_0303, 1, 0, "R6");
        idle("R6");
        // R7 / R12: lowest-word read snapshots
        rd(4, "R7");
        idle("R12");
        // R8: live moves, later word reads return the snapshot
        cyc(0, 0, 0, 0, 1, 48'h9999_8888_7777, 0, 0, "R8");
        rd(5, "R8");
        rd(6, "R8");
        idle("R8");
        // R9: external snapshot, same-cycle read sees live
        cyc(1, 0, 5, 0, 0, 48'h0, 0, 1, "R9");
        cyc(0, 0, 0, 0, 1, 48'h1357_2468_ACE0, 0, 0, "R9");
        rd(6, "R9");
        rd(4, "R9");
        idle("R9");
        // R10: out-of-window requests
        wr(7, 16'hDEAD, "R10");
        wr(2, 16'hDEAD, "R10");
        rd(3, "R10");
        rd(15, "R10");
        wr(6, 16'hAAAA, "R10");
        idle("R10");
        // mixed traffic
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0], lf[1], AW'(lf[5:2]) % 4'd8, {lf[7:0], lf[15:8]}, lf[6] & lf[9],
                {lf, ~lf, lf ^ 16'h5A5A}, lf[8] & lf[3], lf[11] & lf[2], "R2/R6/R8");
        end
        idle("R10");
        summary();
    end
endmodule